// File: doc/BRIEF.md
# Slotted Serial Audio Transmitter

This block turns parallel audio samples into a bit-serial stream organised as frames of time slots. A frame holds one to eight slots. Each slot is one sample container of 8 to 32 bits. A mask selects which slots carry samples and which stay empty. The block produces the frame sync in one of two styles: a level that toggles halfway through the frame, or a pulse of programmable length. It also produces a data output-enable, so the serial line can be released while empty slots pass.

A bit-clock enable strobe, generated elsewhere and one `clk` cycle wide, marks every bit period. A second strobe marks the middle of a bit period and is used only by the early-release line mode. Samples arrive on a valid/ready handshake, one per enabled slot, taken at the moment the slot begins. If no sample is waiting at that moment, the slot is sent as zeros and a sticky underflow flag is raised. All `cfg_*` inputs are static: they are changed only while `rst` is high.

Top module: `tdm_tx`

## Requirements
- R1: The frame is F = S*C bit periods long. S is `cfg_slots_m1`+1. C is the container width: 4*code+4 for a size code of 1..7, so code 1 gives 8 bits and code 7 gives 32 bits. Code 0 is treated as 8 bits. The frame position starts at 0 after reset, advances by one on each `bclk_en`, and wraps from F-1 to 0.
- R2: With `cfg_sync_style`=0 (level style), `fsync` equals `cfg_sync_pol` for positions below floor(F/2) and its inverse for the rest of the frame. A polarity of 0 means the first (left) half is low.
- R3: With `cfg_sync_style`=1 (pulse style), `fsync` is high for positions 0 through `cfg_sync_width`, which is width+1 bit periods, and low for the rest of the frame.
- R4: Data is aligned to the first bit period entered by a `bclk_en` tick whose frame position equals `cfg_offset`. That bit period is bit 0 of slot 0. Before alignment, and always when `cfg_offset` >= F, every slot counts as empty and `sdata` is 0.
- R5: Slot i carries a sample only when bit i of `cfg_slot_en` is 1. Empty slots send 0.
- R6: A sample's low E = C - `cfg_mask_bits` bits form the container word (sample << `cfg_mask_bits`), so the masked low bits are zeros. With `cfg_lsb_first`=0 the word is sent from container bit C-1 down to bit 0. With `cfg_lsb_first`=1 it is sent from bit 0 up to bit C-1.
- R7: `s_ready` is high only in a cycle with `bclk_en` high whose tick enters bit 0 of an enabled slot. Samples are taken in slot order, one per enabled slot.
- R8: With `cfg_hz_mode`=0, `sdata_oe` is always 1. With mode 1 (or code 3, which acts the same), `sdata_oe` is 1 exactly during bit periods of aligned, enabled slots.
- R9: With `cfg_hz_mode`=2, `sdata_oe` follows mode 1. In addition, it drops at a `half_en` strobe during the last bit of an enabled slot when the next slot is empty, which is half a bit period early. The next slot after S-1 is slot 0.
- R10: When an enabled slot begins and `s_valid` is low, the slot is sent as zeros and `underflow` goes high and stays high. `underflow_clr` clears it, and a new underflow in the same cycle wins over the clear.
- R11: After reset: position 0, `sdata`=0, `s_ready`=0, `underflow`=0, and `sdata_oe`=1 only in mode 0. `fsync` and `sdata` change only after a `bclk_en` tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Bit-period strobe, one cycle wide |
| half_en | input | 1 | Mid-bit-period strobe (early-release mode) |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Sample taken this cycle |
| s_data | input | 32 | Sample, right-justified |
| cfg_sync_style | input | 1 | 0 = level sync, 1 = pulse sync |
| cfg_sync_pol | input | 1 | Level-sync value during the first half of the frame |
| cfg_sync_width | input | 8 | Pulse high time minus one, in bit periods |
| cfg_slots_m1 | input | 3 | Slots per frame minus one |
| cfg_slot_en | input | 8 | Per-slot enable, bit i = slot i |
| cfg_size_code | input | 3 | Container size code |
| cfg_mask_bits | input | 3 | Low container bits forced to zero |
| cfg_lsb_first | input | 1 | 0 = MSB first, 1 = LSB first |
| cfg_offset | input | 11 | Frame position of the first data bit |
| cfg_hz_mode | input | 2 | Line release mode |
| underflow_clr | input | 1 | Clear pulse for the underflow flag |
| underflow | output | 1 | Sticky underflow flag |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data output-enable |

## Verification
The hardest case to reach is the early release. It requires the early-release mode, a `half_en` strobe inside the final bit of an enabled slot, and an empty slot right after it, possibly across the frame wrap to slot 0. The bench reaches it by sweeping enable patterns with enabled/empty neighbours over all container sizes and several slot counts, and it checks `sdata_oe` after every mid-bit strobe. Alignment is also hard to reach. An offset of 0 only aligns at the first wrap, and an offset at or beyond the frame length never aligns. Both cases appear in the sweep, together with a withheld sample that forces an underflow in the middle of a frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SLOT_N   = 8;
    localparam int SLOT_W   = $clog2(SLOT_N);
    localparam int CONT_MAX = 32;
    localparam int BIT_W    = $clog2(CONT_MAX);
    localparam int CBITS_W  = BIT_W + 1;
    localparam int POS_W    = $clog2(SLOT_N * CONT_MAX) + 1;
    localparam int OFS_W    = 11;
    localparam int SYNCW_W  = 8;
    localparam int MASK_W   = 3;
    localparam int CODE_W   = 3;

    typedef enum logic [1:0] {
        HZ_DRIVE    = 2'd0,
        HZ_SLOT     = 2'd1,
        HZ_EARLY    = 2'd2,
        HZ_SLOT_ALT = 2'd3
    } hz_mode_e;

    typedef enum logic {
        SYNC_LEVEL = 1'b0,
        SYNC_PULSE = 1'b1
    } sync_style_e;

    // Data coordinates inside the frame, relative to the offset point
    typedef struct packed {
        logic              aligned;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } dpos_t;

    // Container width from size code; code 0 is read as the smallest size
    function automatic logic [CBITS_W-1:0] cont_bits(input logic [CODE_W-1:0] code);
        if (code == '0) return CBITS_W'(8);
        return CBITS_W'({code, 2'b00}) + CBITS_W'(4);
    endfunction

    function automatic logic [POS_W-1:0] frame_bits(input logic [SLOT_W-1:0] slots_m1,
                                                    input logic [CBITS_W-1:0] cont);
        return (POS_W'(slots_m1) + POS_W'(1)) * POS_W'(cont);
    endfunction

endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing
    import tdm_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bclk_en,
    input  logic [SLOT_W-1:0]  slots_m1,
    input  logic [SLOT_N-1:0]  slot_en,
    input  logic [CBITS_W-1:0] cont,
    input  logic [OFS_W-1:0]   offset,
    input  logic               sync_style,
    input  logic               sync_pol,
    input  logic [SYNCW_W-1:0] sync_width,
    output dpos_t              dpos,
    output logic               load,
    output logic               fsync
);

    logic [POS_W-1:0] frame_len;
    logic [POS_W-1:0] pos_q, pos_nx;
    dpos_t            dpos_q, dpos_nx;
    logic             lvl_sync, pulse_sync;

    assign frame_len = frame_bits(slots_m1, cont);

    always_comb begin
        pos_nx  = (pos_q >= frame_len - POS_W'(1)) ? '0 : pos_q + POS_W'(1);
        dpos_nx = dpos_q;
        if (OFS_W'(pos_nx) == offset) begin
            dpos_nx.aligned = 1'b1;
            dpos_nx.slot    = '0;
            dpos_nx.bitn    = '0;
        end else if (dpos_q.aligned) begin
            if ({1'b0, dpos_q.bitn} == cont - CBITS_W'(1)) begin
                dpos_nx.bitn = '0;
                dpos_nx.slot = (dpos_q.slot == slots_m1) ? '0 : dpos_q.slot + SLOT_W'(1);
            end else begin
                dpos_nx.bitn = dpos_q.bitn + BIT_W'(1);
            end
        end
    end

    // A sample is pulled on the tick that enters bit 0 of an enabled slot
    assign load = bclk_en && dpos_nx.aligned && (dpos_nx.bitn == '0) && slot_en[dpos_nx.slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            dpos_q <= '0;
        end else if (bclk_en) begin
            pos_q  <= pos_nx;
            dpos_q <= dpos_nx;
        end
    end

    assign lvl_sync   = (pos_q < (frame_len >> 1)) ? sync_pol : ~sync_pol;
    assign pulse_sync = (pos_q <= POS_W'(sync_width));
    assign fsync      = (sync_style_e'(sync_style) == SYNC_PULSE) ? pulse_sync : lvl_sync;
    assign dpos       = dpos_q;

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                s_valid,
    input  logic [CONT_MAX-1:0] s_data,
    input  logic [CBITS_W-1:0]  cont,
    input  logic [MASK_W-1:0]   mask_bits,
    input  logic                lsb_first,
    input  logic [BIT_W-1:0]    bitn,
    input  logic                uf_clr,
    output logic                bit_out,
    output logic                underflow
);

    logic [CBITS_W-1:0]  eff;
    logic [CONT_MAX-1:0] keep;
    logic [CONT_MAX-1:0] word_nx, word_q;
    logic [BIT_W-1:0]    idx;
    logic                uf_q;

    assign eff     = cont - CBITS_W'(mask_bits);
    assign keep    = CONT_MAX'((64'd1 << eff) - 64'd1);
    assign word_nx = (s_data & keep) << mask_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            uf_q   <= 1'b0;
        end else begin
            if (load) word_q <= s_valid ? word_nx : '0;
            if (load && !s_valid) uf_q <= 1'b1;
            else if (uf_clr)      uf_q <= 1'b0;
        end
    end

    assign idx       = lsb_first ? bitn : BIT_W'(cont - CBITS_W'(1)) - bitn;
    assign bit_out   = word_q[idx];
    assign underflow = uf_q;

endmodule

// File: rtl/tdm_tx_oe.sv
module tdm_tx_oe
    import tdm_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bclk_en,
    input  logic               half_en,
    input  logic [1:0]         hz_mode,
    input  logic               act,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [BIT_W-1:0]   bitn,
    input  logic [SLOT_W-1:0]  slots_m1,
    input  logic [SLOT_N-1:0]  slot_en,
    input  logic [CBITS_W-1:0] cont,
    output logic               oe
);

    hz_mode_e          mode;
    logic [SLOT_W-1:0] next_slot;
    logic              next_empty, last_bit, early_q;

    assign mode       = hz_mode_e'(hz_mode);
    assign next_slot  = (slot == slots_m1) ? '0 : slot + SLOT_W'(1);
    assign next_empty = ~slot_en[next_slot];
    assign last_bit   = ({1'b0, bitn} == cont - CBITS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= 1'b0;
        end else if (bclk_en) begin
            early_q <= 1'b0;
        end else if (half_en && mode == HZ_EARLY && act && last_bit && next_empty) begin
            early_q <= 1'b1;
        end
    end

    assign oe = (mode == HZ_DRIVE) ? 1'b1 : (act & ~early_q);

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_en,
    input  logic                half_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [CONT_MAX-1:0] s_data,
    input  logic                cfg_sync_style,
    input  logic                cfg_sync_pol,
    input  logic [SYNCW_W-1:0]  cfg_sync_width,
    input  logic [SLOT_W-1:0]   cfg_slots_m1,
    input  logic [SLOT_N-1:0]   cfg_slot_en,
    input  logic [CODE_W-1:0]   cfg_size_code,
    input  logic [MASK_W-1:0]   cfg_mask_bits,
    input  logic                cfg_lsb_first,
    input  logic [OFS_W-1:0]    cfg_offset,
    input  logic [1:0]          cfg_hz_mode,
    input  logic                underflow_clr,
    output logic                underflow,
    output logic                fsync,
    output logic                sdata,
    output logic                sdata_oe
);

    logic [CBITS_W-1:0] cont;
    dpos_t              dpos;
    logic               load, act, bit_raw;

    assign cont = cont_bits(cfg_size_code);

    tdm_tx_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .bclk_en    (bclk_en),
        .slots_m1   (cfg_slots_m1),
        .slot_en    (cfg_slot_en),
        .cont       (cont),
        .offset     (cfg_offset),
        .sync_style (cfg_sync_style),
        .sync_pol   (cfg_sync_pol),
        .sync_width (cfg_sync_width),
        .dpos       (dpos),
        .load       (load),
        .fsync      (fsync)
    );

    tdm_tx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .cont      (cont),
        .mask_bits (cfg_mask_bits),
        .lsb_first (cfg_lsb_first),
        .bitn      (dpos.bitn),
        .uf_clr    (underflow_clr),
        .bit_out   (bit_raw),
        .underflow (underflow)
    );

    assign act = dpos.aligned & cfg_slot_en[dpos.slot];

    tdm_tx_oe u_oe (
        .clk      (clk),
        .rst      (rst),
        .bclk_en  (bclk_en),
        .half_en  (half_en),
        .hz_mode  (cfg_hz_mode),
        .act      (act),
        .slot     (dpos.slot),
        .bitn     (dpos.bitn),
        .slots_m1 (cfg_slots_m1),
        .slot_en  (cfg_slot_en),
        .cont     (cont),
        .oe       (sdata_oe)
    );

    assign sdata   = act & bit_raw;
    assign s_ready = load;

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       bclk_en,
    input logic       s_valid,
    input logic       s_ready,
    input logic       underflow_clr,
    input logic       underflow,
    input logic       fsync,
    input logic       sdata,
    input logic       sdata_oe,
    input logic [1:0] cfg_hz_mode
);

    // R7
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> bclk_en);

    // R10
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid) |=> underflow);

    // R10
    underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !underflow_clr) |=> underflow);

    // R8
    drive_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_hz_mode == 2'd0) |-> sdata_oe);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_hz_mode == 2'd1 && !sdata_oe) |-> !sdata);

    // R11
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> ($stable(fsync) && $stable(sdata)));

endmodule

bind tdm_tx tdm_tx_chk u_chk (.*);

// File: tb/tdm_tx_bench.sv
`timescale 1ns/1ps
module tdm_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0, half_en = 1'b0;
    logic        s_valid = 1'b1;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        cfg_sync_style = 1'b0, cfg_sync_pol = 1'b0;
    logic [7:0]  cfg_sync_width = '0;
    logic [2:0]  cfg_slots_m1 = '0;
    logic [7:0]  cfg_slot_en = '0;
    logic [2:0]  cfg_size_code = 3'd1, cfg_mask_bits = '0;
    logic        cfg_lsb_first = 1'b0;
    logic [10:0] cfg_offset = '0;
    logic [1:0]  cfg_hz_mode = '0;
    logic        underflow_clr = 1'b0;
    logic        underflow, fsync, sdata, sdata_oe;

    int checks = 0, failures = 0;
    int C, S, F, t0;

    always #2.5 clk = ~clk;

    tdm_tx u_tdm_tx (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void expos(input int t, output bit al, output int sl, output int bt);
        int q;
        al = 0; sl = 0; bt = 0;
        if (t0 >= 0 && t >= t0) begin
            q  = t - t0;
            al = 1;
            sl = (q / C) % S;
            bt = q % C;
        end
    endfunction

    function automatic logic [31:0] fmt(input logic [31:0] d);
        int e;
        logic [31:0] keep;
        e = C - int'(cfg_mask_bits);
        keep = (e >= 32) ? 32'hFFFF_FFFF : ((32'd1 << e) - 32'd1);
        return (d & keep) << cfg_mask_bits;
    endfunction

    function automatic bit exp_sync(input int t);
        int p;
        p = t % F;
        if (cfg_sync_style) return (p <= int'(cfg_sync_width));
        return (p < F / 2) ? cfg_sync_pol : !cfg_sync_pol;
    endfunction

    task automatic run_cfg(input int idx, input int drop);
        bit al, act, start, ebit, eoe;
        int sl, bt, nper, k, lc, bi, ns;
        logic [31:0] cw;
        bit euf;
        string rq;
        C  = (cfg_size_code == 0) ? 8 : 4 * int'(cfg_size_code) + 4;
        S  = int'(cfg_slots_m1) + 1;
        F  = C * S;
        t0 = (int'(cfg_offset) < F) ? ((cfg_offset == 0) ? F : int'(cfg_offset)) : -1;
        nper = ((t0 > 0) ? t0 : F) + 2 * F;
        k = 0; lc = 0; cw = '0; euf = 0;
        @(negedge clk); rst = 1'b0;
        // R11 reset state
        chk(fsync == exp_sync(0), "R11", "fsync at reset", fsync, exp_sync(0));
        chk(sdata == 1'b0, "R11", "sdata at reset", sdata, 0);
        chk(sdata_oe == (cfg_hz_mode == 0), "R11", "oe at reset", sdata_oe, cfg_hz_mode == 0);
        chk(underflow == 1'b0 && s_ready == 1'b0, "R11", "uf/ready at reset",
            {underflow, s_ready}, 0);
        for (int t = 1; t <= nper; t++) begin
            @(negedge clk);
            bclk_en = 1'b1;
            s_valid = (lc != drop);
            s_data  = 32'h9E37_79B9 * (k + 1) ^ (idx << 24);
            #1;
            expos(t, al, sl, bt);
            start = al && bt == 0 && cfg_slot_en[sl];
            chk(s_ready == start, "R7", $sformatf("ready t=%0d cfg=%0d", t, idx), s_ready, start);
            if (start) begin
                if (s_valid) begin cw = fmt(s_data); k++; end
                else begin cw = '0; euf = 1; end
                lc++;
            end
            @(negedge clk);
            bclk_en = 1'b0;
            act  = al && cfg_slot_en[sl];
            bi   = cfg_lsb_first ? bt : C - 1 - bt;
            ebit = act && cw[bi];
            rq   = ((t % F) == 0) ? "R1" : (cfg_sync_style ? "R3" : "R2");
            chk(fsync == exp_sync(t), rq, $sformatf("fsync t=%0d cfg=%0d", t, idx), fsync, exp_sync(t));
            rq   = !al ? "R4" : (!cfg_slot_en[sl] ? "R5" : (s_valid ? "R6" : "R10"));
            chk(sdata == ebit, rq, $sformatf("sdata t=%0d cfg=%0d", t, idx), sdata, ebit);
            eoe  = (cfg_hz_mode == 0) ? 1'b1 : act;
            chk(sdata_oe == eoe, "R8", $sformatf("oe t=%0d cfg=%0d", t, idx), sdata_oe, eoe);
            half_en = 1'b1;
            @(negedge clk);
            half_en = 1'b0;
            ns = (sl + 1) % S;
            if (cfg_hz_mode == 2 && act && bt == C - 1 && !cfg_slot_en[ns]) eoe = 1'b0;
            rq = (cfg_hz_mode == 2) ? "R9" : "R8";
            chk(sdata_oe == eoe, rq, $sformatf("oe half t=%0d cfg=%0d", t, idx), sdata_oe, eoe);
        end
        chk(underflow == euf, "R10", $sformatf("sticky flag cfg=%0d", idx), underflow, euf);
        underflow_clr = 1'b1;
        @(negedge clk);
        underflow_clr = 1'b0;
        chk(underflow == 1'b0, "R10", "flag after clear", underflow, 0);
        s_valid = 1'b1;
        rst = 1'b1;
    endtask

    task automatic set_cfg(input int sc, input int sm, input int idx, input int off, input int hz);
        logic [7:0] pats [4];
        pats[0] = 8'b1011_0101; pats[1] = 8'b0110_1101;
        pats[2] = 8'b1111_1110; pats[3] = 8'b1100_1011;
        @(negedge clk);
        rst            = 1'b1;
        cfg_size_code  = 3'(sc);
        cfg_slots_m1   = 3'(sm);
        cfg_mask_bits  = 3'((sc + sm) % 8);
        cfg_lsb_first  = 1'((sc + sm) & 1);
        cfg_slot_en    = pats[idx % 4];
        cfg_offset     = 11'(off);
        cfg_sync_style = 1'(idx & 1);
        cfg_sync_pol   = 1'((idx >> 1) & 1);
        cfg_sync_width = 8'((idx * 5) % 12);
        cfg_hz_mode    = 2'(hz);
        @(negedge clk);
    endtask

    initial begin
        int idx, sm, fl, off;
        idx = 0;
        repeat (3) @(negedge clk);
        for (int sc = 1; sc <= 7; sc++) begin
            for (int j = 0; j < 4; j++) begin
                sm  = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 3 : 7;
                fl  = (4 * sc + 4) * (sm + 1);
                off = (idx % 4 == 0) ? 0 : (idx * 7) % fl;
                set_cfg(sc, sm, idx, off, idx % 3);
                run_cfg(idx, (idx % 5 == 2) ? 1 : -1);
                idx++;
            end
        end
        // R4: offset beyond the frame never aligns
        set_cfg(1, 0, idx, 20, 1);
        run_cfg(idx, -1); idx++;
        // R1: size code 0 read as 8-bit container
        set_cfg(0, 1, idx, 3, 2);
        run_cfg(idx, 2); idx++;
        // R8: mode code 3 releases like mode 1
        set_cfg(2, 3, idx, 5, 3);
        run_cfg(idx, -1); idx++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule